// File: doc/BRIEF.md
# Configurable GPIO port controller

This block is a general-purpose I/O port of `WIDTH` pins with three registers that a CPU can read and write: an output latch, a direction mask and a per-pin option mask. It sits on a simple register bus (offset, write strobe, write data and combinational read data). On the pad side it drives, for each pin, an output value, an output enable and a pull-up enable, and it samples each pin's input level.

Each pin takes its mode from its direction bit and its option bit. As an input, the option bit chooses a floating pin or an interrupt source with its pull-up on. As an output, the option bit chooses open-drain or push-pull drive. Pins can be built without an option bit, and push-pull can be forbidden on chosen pins, which then fall back to open-drain. Every pad input passes through a two-flop synchroniser. A falling edge on an interrupt input sets a sticky pending flag. Any write to the data register clears all pending flags. The port interrupt is the OR of the pending flags.

Top module: `gpio_port`

## Requirements
- R1: After reset the data, direction and option registers read 00h, `pad_oe`, `pad_pu` and `pad_out` are all zero, and `irq` is low.
- R2: Offset 0 is the data register, offset 1 the direction register (bit = 1 output, 0 input) and offset 2 the option register. Direction and option read back what was written. A read at offset 3 returns 00h.
- R3: A write to offset 0 always loads the output latch, even while the pins are inputs. The loaded value becomes visible once the pins are switched to outputs.
- R4: A read of offset 0 returns, bit by bit, the latch for output pins and the synchronised pad level for input pins.
- R5: A change on `pad_in` appears in the data read-back after the second rising clock edge, and not after the first.
- R6: An input pin whose option bit is 0 is floating: output enable 0, pull-up 0, and a falling edge on it raises no interrupt.
- R7: An input pin whose option bit is 1 has its pull-up on. A falling edge of its synchronised level sets a sticky pending flag, and `irq` goes high after the third clock edge following the pad change. A rising edge sets nothing.
- R8: A write to offset 0 clears all pending flags, and `irq` drops after that edge.
- R9: An output pin whose option bit is 0 is open-drain: `pad_out` is 0 and `pad_oe` equals the inverted latch bit.
- R10: An output pin whose option bit is 1 is push-pull (`pad_oe` = 1, `pad_out` = latch bit). On pins flagged in `PP_RESERVED` it behaves as open-drain instead.
- R11: On pins cleared in `OPT_IMPL` the option bit reads 0 and ignores writes, so such a pin is a floating input or an open-drain output, as its direction bit selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr` (combinational) |
| pad_in | input | WIDTH | Pad input levels (asynchronous) |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| pad_pu | output | WIDTH | Pad pull-up enables |
| irq | output | 1 | Port interrupt request, OR of pending flags |

## Verification
The bench builds the port with `OPT_IMPL = 8'h7F` and `PP_RESERVED = 8'h30`. One pin then has no option bit, and two pins cannot use push-pull. With these values a single register write exercises every mode: push-pull, forced open-drain, plain open-drain, floating and interrupt inputs. The bench also checks the masked read-back of the option register and the fallback of a pin with no option bit, alongside the latency of the synchroniser and of the interrupt path.

// File: rtl/gpio_pkg.sv
// Package: shared register offsets and pin-mode encoding for the GPIO port.
// Assumes a 2-bit register offset on the CPU bus.
package gpio_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_OPT  = 2'd2;

    typedef enum logic [1:0] {
        PM_FLOAT_IN = 2'b00,
        PM_IRQ_IN   = 2'b01,
        PM_OD_OUT   = 2'b10,
        PM_PP_OUT   = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no cross-bit coherence is implied.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two register stages per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
// Module: data latch, direction and option registers with read-back mux.
// Assumes single-cycle write strobes; reads are combinational on the offset.
// Option bits cleared in OPT_IMPL are never stored and read as zero.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] OPT_IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  opt_q,
    output logic              data_wr
);
    logic dir_wr;
    logic opt_wr;

    assign data_wr = bus_we && (bus_addr == OFS_DATA);
    assign dir_wr  = bus_we && (bus_addr == OFS_DIR);
    assign opt_wr  = bus_we && (bus_addr == OFS_OPT);

    // Output latch: loaded by every data write regardless of direction.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (data_wr) latch_q <= bus_wdata;
    end

    // Direction register: 1 = output, 0 = input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_wr) dir_q <= bus_wdata;
    end

    // Option register: unimplemented bits are held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      opt_q <= '0;
        else if (opt_wr) opt_q <= bus_wdata & OPT_IMPL;
    end

    // Read-back mux: data reads mix latch and pin per direction bit.
    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = (latch_q & dir_q) | (pin_sync & ~dir_q);
            OFS_DIR:  bus_rdata = dir_q;
            OFS_OPT:  bus_rdata = opt_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: per-pin mode decoder driving pad controls from register bits.
// Assumes PP_ALLOWED is 0 on pins where push-pull drive is reserved; such
// pins use open-drain drive when push-pull is requested.
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter bit PP_ALLOWED = 1'b1
) (
    input  logic latch_bit,
    input  logic dir_bit,
    input  logic opt_bit,
    output logic pad_out_bit,
    output logic pad_oe_bit,
    output logic pad_pu_bit,
    output logic irq_en_bit
);
    pin_mode_e mode;

    // Decode direction and option into a pin mode, applying the reservation.
    always_comb begin
        mode = pin_mode_e'({dir_bit, opt_bit});
        if (!PP_ALLOWED && mode == PM_PP_OUT) mode = PM_OD_OUT;
    end

    // Drive pad controls from the decoded mode.
    always_comb begin
        pad_out_bit = 1'b0;
        pad_oe_bit  = 1'b0;
        pad_pu_bit  = 1'b0;
        irq_en_bit  = 1'b0;
        unique case (mode)
            PM_FLOAT_IN: ;
            PM_IRQ_IN: begin
                pad_pu_bit = 1'b1;
                irq_en_bit = 1'b1;
            end
            PM_OD_OUT: pad_oe_bit = ~latch_bit;
            PM_PP_OUT: begin
                pad_oe_bit  = 1'b1;
                pad_out_bit = latch_bit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_irq.sv
// Module: falling-edge detector with sticky pending flags per pin.
// Assumes synchronised inputs; a clear and a new edge in the same cycle
// leave the new edge pending.
module gpio_irq #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] irq_en,
    input  logic             clear,
    output logic [WIDTH-1:0] fall_vec,
    output logic             irq
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] pend_q;

    // Previous synchronised level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    assign fall_vec = prev_q & ~pin_sync & irq_en;

    // Pending flags: set on enabled falling edge, cleared by a data write.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= '0;
        else if (clear) pend_q <= fall_vec;
        else            pend_q <= pend_q | fall_vec;
    end

    assign irq = |pend_q;
endmodule

// File: rtl/gpio_port.sv
// Module: top of the configurable GPIO port.
// Assumes asynchronous pad inputs and a synchronous CPU register bus.
// OPT_IMPL marks pins with an option bit; PP_RESERVED marks pins where
// push-pull drive is not allowed.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] OPT_IMPL    = '1,
    parameter logic [WIDTH-1:0] PP_RESERVED = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu,
    output logic              irq
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] opt_q;
    logic [WIDTH-1:0] irq_en;
    logic [WIDTH-1:0] fall_vec;
    logic             data_wr;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .OPT_IMPL(OPT_IMPL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .opt_q     (opt_q),
        .data_wr   (data_wr)
    );

    // One mode decoder per pin, each with its own push-pull permission.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        gpio_pin_ctrl #(.PP_ALLOWED(!PP_RESERVED[i])) u_pin (
            .latch_bit   (latch_q[i]),
            .dir_bit     (dir_q[i]),
            .opt_bit     (opt_q[i]),
            .pad_out_bit (pad_out[i]),
            .pad_oe_bit  (pad_oe[i]),
            .pad_pu_bit  (pad_pu[i]),
            .irq_en_bit  (irq_en[i])
        );
    end

    gpio_irq #(.WIDTH(WIDTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .irq_en   (irq_en),
        .clear    (data_wr),
        .fall_vec (fall_vec),
        .irq      (irq)
    );
endmodule

// File: rtl/gpio_port_chk.sv
// Module: assertion checker for gpio_port, attached through bind.
// Assumes it sees the top ports plus the direction register and edge vector.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] OPT_IMPL    = '1,
    parameter logic [WIDTH-1:0] PP_RESERVED = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu,
    input logic              irq,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  fall_vec
);
    // R6: an input pin never drives its pad.
    p_no_drive_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    // R7: pull-up is only on for pins that do not drive.
    p_pullup_not_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R7: pending interrupt stays until a data write.
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_we && bus_addr == OFS_DATA)) |=> irq);

    // R8: a data write with no concurrent edge leaves nothing pending.
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DATA && fall_vec == '0) |=> !irq);

    // R10: a high output value is only presented when driven, never on reserved pins.
    p_out_only_driven_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0) && ((pad_out & PP_RESERVED) == '0));

    // R11: unimplemented option bits always read as zero.
    p_opt_unimpl_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_OPT) |-> ((bus_rdata & ~OPT_IMPL) == '0));

    // R2: the unmapped offset reads zero.
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH(WIDTH), .OPT_IMPL(OPT_IMPL), .PP_RESERVED(PP_RESERVED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .irq(irq), .dir_q(dir_q), .fall_vec(fall_vec)
);

// File: tb/tb_gpio_port.sv
// Bench: directed scenarios for gpio_port, one task each, self-checking.
module tb_gpio_port;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 8;
    localparam logic [W-1:0] OPT_MASK  = 8'h7F;
    localparam logic [W-1:0] PP_RES    = 8'h30;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out, pad_oe, pad_pu;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    gpio_port #(.WIDTH(W), .OPT_IMPL(OPT_MASK), .PP_RESERVED(PP_RES)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive a write at a falling edge, commit at the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        rd(2'd0, d); check("R1", "data after reset", d, 8'h00);
        rd(2'd1, d); check("R1", "dir after reset", d, 8'h00);
        rd(2'd2, d); check("R1", "opt after reset", d, 8'h00);
        check("R1", "oe after reset", pad_oe, 8'h00);
        check("R1", "pu after reset", pad_pu, 8'h00);
        check("R1", "out after reset", pad_out, 8'h00);
        check("R1", "irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_regs();
        logic [W-1:0] d;
        wr(2'd1, 8'hA5); rd(2'd1, d); check("R2", "dir readback", d, 8'hA5);
        wr(2'd2, 8'h3C); rd(2'd2, d); check("R2", "opt readback", d, 8'h3C);
        rd(2'd3, d); check("R2", "unmapped read", d, 8'h00);
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R11", "opt masked readback", d, 8'h7F);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_latch();
        logic [W-1:0] d;
        pad_in = 8'h00; settle();
        wr(2'd0, 8'h96); rd(2'd0, d); check("R4", "input pins read pad", d, 8'h00);
        wr(2'd1, 8'hFF); rd(2'd0, d); check("R3", "latch written while input", d, 8'h96);
        wr(2'd1, 8'hF0); pad_in = 8'h0F; settle();
        rd(2'd0, d); check("R4", "mixed direction read", d, 8'h9F);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_sync();
        logic [W-1:0] d;
        pad_in = 8'h00; settle();
        bus_addr = 2'd0;
        @(negedge clk); pad_in = 8'hFF;
        @(negedge clk); rd(2'd0, d); check("R5", "after first edge", d, 8'h00);
        @(negedge clk); rd(2'd0, d); check("R5", "after second edge", d, 8'hFF);
    endtask

    task automatic t_modes();
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); settle();
        check("R6", "floating oe", pad_oe, 8'h00);
        check("R6", "floating pu", pad_pu, 8'h00);
        wr(2'd2, 8'hFF);
        check("R7", "irq input pull-ups", pad_pu, 8'h7F);
        check("R11", "no-option pin floating", {7'd0, pad_pu[7]}, 8'h00);
        wr(2'd1, 8'hFF); wr(2'd0, 8'hA5);
        check("R10", "push-pull/reserved oe", pad_oe, 8'h5F);
        check("R10", "push-pull out", pad_out, 8'h05);
        check("R11", "no-option pin open-drain", {7'd0, pad_oe[7]}, 8'h00);
        wr(2'd2, 8'h00);
        check("R9", "open-drain oe", pad_oe, 8'h5A);
        check("R9", "open-drain out", pad_out, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_irq();
        wr(2'd2, 8'h03); pad_in = 8'hFF; settle();
        wr(2'd0, 8'h00);
        check("R8", "clean start", {7'd0, irq}, 8'h00);
        @(negedge clk); pad_in = 8'hFE;
        @(negedge clk); @(negedge clk);
        check("R7", "irq not yet after two edges", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R7", "irq after third edge", {7'd0, irq}, 8'h01);
        pad_in = 8'hFF; settle();
        check("R7", "sticky after rise", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h00);
        check("R8", "cleared by data write", {7'd0, irq}, 8'h00);
        pad_in = 8'hFB; settle();
        check("R6", "floating pin fall no irq", {7'd0, irq}, 8'h00);
        pad_in = 8'hFF; settle();
        check("R7", "rising edge no irq", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_latch();
        t_sync();
        t_modes();
        t_irq();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule